// File: doc/BRIEF.md
# SECDED Memory Datapath with Diagnostic Controls

This block sits between a single requester and a 72-bit wide memory word (64 data bits plus an 8-bit check byte). On every write it computes a single-error-correct, double-error-detect code over the data and stores it in the check byte. On every read it recomputes the code, forms an 8-bit syndrome and classifies the word as clean, single-error or multi-error. Depending on the configured mode, it either returns the corrected word or returns the raw word and only reports the error. A write whose byte enables are not all set is carried out as a read-modify-write. The read phase goes through the same check path, so a correctable error in a byte that is kept is repaired before the write-back.

A small register port sets the ECC mode, a diagnostic switch that forces the stored check byte to zero, and the error-report enables. The same port reads and clears sticky error flags, the last failing syndrome and the last failing address. A registered system-error level is derived from the enabled sticky flags. The code uses odd-weight columns: each data bit maps to a distinct weight-3 or weight-5 column, and each check bit to a weight-1 column. An odd-weight syndrome is therefore treated as a correctable single error, and a nonzero even-weight syndrome as uncorrectable.

Top module: `secded_mem_path`

## Requirements
- R1: With the mode field set to correct (CTRL[1:0] = 2, or 3, which behaves the same), a write with all eight byte enables stores the data unchanged in memory bits [63:0]. A later read of that word returns the same data and sets no error flag.
- R2: In correct mode, a single flipped data bit is corrected in the returned data. The read sets the single-error flag (STATUS bit 0) and records an odd-weight syndrome in STATUS[15:8] and the word address in the error-address register (register index 2).
- R3: A single flipped check bit k returns the data unchanged and records a syndrome equal to 1 << k.
- R4: Two flipped data bits in one word set the multi-error flag (STATUS bit 1) and leave the single-error flag clear. The returned data is the stored word, not corrected.
- R5: In check-only mode (CTRL[1:0] = 1), a single-bit error sets the single-error flag, and the data is returned with the error still in it.
- R6: In off mode (CTRL[1:0] = 0), every write drives the check byte as 0x00. Reads are neither checked nor corrected, and they never set a flag.
- R7: While the diagnostic bit (CTRL bit 2) is set, every write stores check byte 0x00. This applies to full writes and to the write-back of a read-modify-write.
- R8: While the diagnostic bit is set, reads are still checked and errors are logged, but the data is never corrected.
- R9: A write with some byte enables clear reads the word, replaces only the enabled bytes and writes back a freshly encoded word. In correct mode, a single-bit error in a kept byte is repaired in the stored word.
- R10: If the read phase of a read-modify-write finds an uncorrectable error, the merge and write-back still complete using the raw read data, and the multi-error flag is set.
- R11: The error flags are sticky. Each flag clears only when 1 is written to its bit in STATUS (register index 1), and writing 0 leaves it set.
- R12: sys_err is a registered level that rises one cycle after the condition becomes true. The condition is: the global enable (CTRL bit 5) is set, and either the single flag is set with single reporting (CTRL bit 4) enabled, or the multi flag is set with multi reporting (CTRL bit 3) enabled.
- R13: req_ready is high only when the block is idle. A read's rsp_valid is high for exactly the cycle after the request is accepted. A partial write keeps req_ready low for the two cycles after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for a write |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data (corrected or raw according to mode) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (else read, data next cycle) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 72 | Check byte in [71:64], data in [63:0] |
| mem_rdata | input | 72 | Memory read word, one cycle after a read strobe |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register index: 0 control, 1 status, 2 error address |
| cfg_wdata | input | CFG_DW | Register write data |
| cfg_rdata | output | CFG_DW | Register read data (combinational) |
| sys_err | output | 1 | Registered system-error level |

## Verification
The assertions check, on every cycle, the properties that can be seen at the ports at any time. A write in diagnostic or off mode never carries a nonzero check byte. Read data is valid only in the cycle after a read was accepted, and the block refuses requests while a multi-cycle access is in progress. sys_err rises only with the global enable set and does not drop without a register write. Correction, classification and merging depend on which bits were damaged in memory, so only the bench's scenarios show them: syndrome values for check-bit faults, uncorrected data in check-only and diagnostic modes, repair of a kept byte during a read-modify-write, and the forced merge after a double fault.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int NBYTES = DATA_W / 8;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_CHECK = 2'd1,
    MODE_FIX   = 2'd2,
    MODE_FIX2  = 2'd3
  } ecc_mode_e;

  // control register image, LSB first: mode, diag, rep_multi, rep_single, glob_en
  typedef struct packed {
    logic      glob_en;
    logic      rep_single;
    logic      rep_multi;
    logic      diag;
    ecc_mode_e mode;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WBACK = 2'd2
  } path_state_e;

  function automatic int unsigned weight8(input logic [7:0] v);
    int unsigned n;
    n = 0;
    for (int b = 0; b < 8; b++) n += int'(v[b]);
    return n;
  endfunction

  // distinct odd-weight columns: all weight-3 values, then weight-5 ones
  function automatic logic [DATA_W-1:0][CHK_W-1:0] make_columns();
    logic [DATA_W-1:0][CHK_W-1:0] t;
    int n;
    t = '0;
    n = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        if (weight8(v[7:0]) == ((pass == 0) ? 3 : 5) && n < DATA_W) begin
          t[n] = v[7:0];
          n++;
        end
      end
    end
    return t;
  endfunction

  localparam logic [DATA_W-1:0][CHK_W-1:0] H_COLS = make_columns();
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  always_comb begin
    chk = '0;
    for (int i = 0; i < DATA_W; i++) begin
      for (int j = 0; j < CHK_W; j++) begin
        chk[j] = chk[j] ^ (data[i] & H_COLS[i][j]);
      end
    end
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic              fix_en,
  output logic [CHK_W-1:0]  syndrome,
  output logic              err_single,
  output logic              err_multi,
  output logic [DATA_W-1:0] data_out
);
  logic [CHK_W-1:0] chk_calc;

  secded_enc u_recalc (
    .data (data),
    .chk  (chk_calc)
  );

  assign syndrome   = chk_calc ^ chk_in;
  assign err_single = (|syndrome) &  (^syndrome);
  assign err_multi  = (|syndrome) & ~(^syndrome);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_fix
      assign data_out[gi] = data[gi] ^ (fix_en & err_single & (syndrome == H_COLS[gi]));
    end
  endgenerate
endmodule

// File: rtl/ecc_csr.sv
module ecc_csr
  import secded_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CFG_AW = 2,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              log_en,
  input  logic              log_single,
  input  logic              log_multi,
  input  logic [CHK_W-1:0]  log_syn,
  input  logic [ADDR_W-1:0] log_addr,
  output ctrl_t             ctrl,
  output logic              sys_err
);
  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CFG_AW-1:0] IDX_CTRL  = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] IDX_STAT  = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] IDX_EADDR = CFG_AW'(2);

  ctrl_t             ctrl_q, ctrl_d;
  logic              one_q, one_d;
  logic              many_q, many_d;
  logic [CHK_W-1:0]  syn_q;
  logic [ADDR_W-1:0] eaddr_q;
  logic              ctrl_en, cap_en, serr_d, serr_q;
  logic              unused_wbits;

  assign unused_wbits = ^cfg_wdata[CFG_DW-1:CTRL_W];

  always_comb begin
    ctrl_en = cfg_we && (cfg_addr == IDX_CTRL);
    ctrl_d  = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    one_d   = one_q;
    many_d  = many_q;
    if (cfg_we && cfg_addr == IDX_STAT) begin
      if (cfg_wdata[0]) one_d  = 1'b0;
      if (cfg_wdata[1]) many_d = 1'b0;
    end
    // a new error in the same cycle wins over a clear
    if (log_en && log_single) one_d  = 1'b1;
    if (log_en && log_multi)  many_d = 1'b1;
    cap_en = log_en && (log_single || log_multi);
    serr_d = ctrl_q.glob_en &&
             ((ctrl_q.rep_single && one_q) || (ctrl_q.rep_multi && many_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      one_q   <= 1'b0;
      many_q  <= 1'b0;
      syn_q   <= '0;
      eaddr_q <= '0;
      serr_q  <= 1'b0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      one_q  <= one_d;
      many_q <= many_d;
      if (cap_en) begin
        syn_q   <= log_syn;
        eaddr_q <= log_addr;
      end
      serr_q <= serr_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      IDX_CTRL:  cfg_rdata[CTRL_W-1:0] = ctrl_q;
      IDX_STAT:  cfg_rdata[15:0] = {syn_q, 6'b0, many_q, one_q};
      IDX_EADDR: cfg_rdata[ADDR_W-1:0] = eaddr_q;
      default:   cfg_rdata = '0;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign sys_err = serr_q;
endmodule

// File: rtl/secded_mem_path.sv
module secded_mem_path
  import secded_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CFG_AW = 2,
  parameter int CFG_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NBYTES-1:0] req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic              sys_err
);
  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  path_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [NBYTES-1:0] be_q, be_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] merge_q, merge_d;
  logic              cap_en, merge_en;

  ctrl_t             ctrl_q;
  logic              fix_en, chk_zero, log_en;
  logic [DATA_W-1:0] enc_in;
  logic [CHK_W-1:0]  enc_chk, chk_out;
  logic [CHK_W-1:0]  dec_syn;
  logic              dec_single, dec_multi;
  logic [DATA_W-1:0] dec_data, merged;

  assign fix_en   = (ctrl_q.mode == MODE_FIX || ctrl_q.mode == MODE_FIX2) && !ctrl_q.diag;
  assign chk_zero = (ctrl_q.mode == MODE_OFF) || ctrl_q.diag;

  assign enc_in  = (state_q == ST_WBACK) ? merge_q : req_wdata;
  assign chk_out = chk_zero ? '0 : enc_chk;

  secded_enc u_enc (
    .data (enc_in),
    .chk  (enc_chk)
  );

  secded_dec u_dec (
    .data       (mem_rdata[DATA_W-1:0]),
    .chk_in     (mem_rdata[WORD_W-1:DATA_W]),
    .fix_en     (fix_en),
    .syndrome   (dec_syn),
    .err_single (dec_single),
    .err_multi  (dec_multi),
    .data_out   (dec_data)
  );

  genvar gb;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_merge
      assign merged[gb*8 +: 8] = be_q[gb] ? wdata_q[gb*8 +: 8] : dec_data[gb*8 +: 8];
    end
  endgenerate

  always_comb begin
    state_d   = state_q;
    addr_d    = req_addr;
    wdata_d   = req_wdata;
    be_d      = req_be;
    wr_d      = req_write;
    merge_d   = merged;
    cap_en    = 1'b0;
    merge_en  = 1'b0;
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    log_en    = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = {chk_out, enc_in};
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        mem_addr  = req_addr;
        if (req_valid) begin
          mem_en = 1'b1;
          if (req_write && (&req_be)) begin
            mem_we = 1'b1;
          end else begin
            cap_en  = 1'b1;
            state_d = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        log_en    = (ctrl_q.mode != MODE_OFF);
        rsp_valid = !wr_q;
        if (wr_q) begin
          merge_en = 1'b1;
          state_d  = ST_WBACK;
        end else begin
          state_d  = ST_IDLE;
        end
      end
      ST_WBACK: begin
        mem_en  = 1'b1;
        mem_we  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      merge_q <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
        be_q    <= be_d;
        wr_q    <= wr_d;
      end
      if (merge_en) merge_q <= merge_d;
    end
  end

  assign rsp_rdata = dec_data;

  ecc_csr #(
    .ADDR_W (ADDR_W),
    .CFG_AW (CFG_AW),
    .CFG_DW (CFG_DW)
  ) u_csr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .log_en     (log_en),
    .log_single (dec_single),
    .log_multi  (dec_multi),
    .log_syn    (dec_syn),
    .log_addr   (addr_q),
    .ctrl       (ctrl_q),
    .sys_err    (sys_err)
  );
endmodule

// File: rtl/secded_mem_path_chk.sv
module secded_mem_path_chk
  import secded_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [NBYTES-1:0] req_be,
  input logic              rsp_valid,
  input logic              mem_en,
  input logic              mem_we,
  input logic [CHK_W-1:0]  mem_chk,
  input ctrl_t             ctrl,
  input logic              cfg_we,
  input logic              sys_err
);
  // R7
  diag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && ctrl.diag) |-> (mem_chk == '0));

  // R6
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && ctrl.mode == MODE_OFF) |-> (mem_chk == '0));

  // R13
  rsp_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  // R13
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_ready && (!req_write || req_be != '1)) |-> !req_ready);

  // R12
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err |-> $past(ctrl.glob_en));

  // R11
  serr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sys_err) && !$past(cfg_we) && !$past(cfg_we, 2)) |-> sys_err);
endmodule

bind secded_mem_path secded_mem_path_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_be    (req_be),
  .rsp_valid (rsp_valid),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_chk   (mem_wdata[71:64]),
  .ctrl      (ctrl_q),
  .cfg_we    (cfg_we),
  .sys_err   (sys_err)
);

// File: tb/tb_secded_mem_path.sv
module tb_secded_mem_path;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [63:0] req_wdata;
  logic [7:0]  req_be;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [71:0] mem_wdata, mem_rdata;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        sys_err;

  logic [71:0] mem [256];

  int n_chk = 0;
  int n_fail = 0;

  secded_mem_path #(.ADDR_W(AW), .CFG_AW(2), .CFG_DW(32)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sys_err(sys_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  task automatic check_eq(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic mem_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (be != 8'hFF) begin
      check_eq("R13 ready low after partial accept", 72'(req_ready), 72'(0));
      @(negedge clk);
      check_eq("R13 ready low in write-back", 72'(req_ready), 72'(0));
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic mem_read(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check_eq("R13 rsp_valid one cycle after accept", 72'(rsp_valid), 72'(1));
    d = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    check_eq("R13 rsp_valid single cycle", 72'(rsp_valid), 72'(0));
  endtask

  task automatic t_reset();
    logic [31:0] r;
    cfg_rd(2'd0, r); check_eq("reset ctrl", 72'(r), 72'(0));
    cfg_rd(2'd1, r); check_eq("reset status", 72'(r), 72'(0));
    check_eq("reset sys_err", 72'(sys_err), 72'(0));
    check_eq("reset req_ready", 72'(req_ready), 72'(1));
  endtask

  task automatic t_clean_rw();  // R1
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h02);
    mem_write(8'd5, 64'hA5A5_0F0F_1234_5678, 8'hFF);
    check_eq("R1 stored data", 72'(mem[5][63:0]), 72'(64'hA5A5_0F0F_1234_5678));
    mem_read(8'd5, d);
    check_eq("R1 read data", 72'(d), 72'(64'hA5A5_0F0F_1234_5678));
    cfg_rd(2'd1, r); check_eq("R1 no flags", 72'(r[1:0]), 72'(0));
  endtask

  task automatic t_single_fix();  // R2 R12
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h32);
    mem[5][17] = ~mem[5][17];
    mem_read(8'd5, d);
    check_eq("R2 corrected data", 72'(d), 72'(64'hA5A5_0F0F_1234_5678));
    cfg_rd(2'd1, r);
    check_eq("R2 flags single", 72'(r[1:0]), 72'(1));
    check_eq("R2 syndrome odd weight", 72'(^r[15:8]), 72'(1));
    cfg_rd(2'd2, r); check_eq("R2 error address", 72'(r), 72'(5));
    check_eq("R12 sys_err not yet", 72'(sys_err), 72'(0));
    @(negedge clk);
    check_eq("R12 sys_err raised", 72'(sys_err), 72'(1));
    cfg_wr(2'd1, 32'h1);
    cfg_rd(2'd1, r); check_eq("R11 single cleared by 1", 72'(r[1:0]), 72'(0));
    @(negedge clk);
    check_eq("R12 sys_err dropped", 72'(sys_err), 72'(0));
  endtask

  task automatic t_chk_bit();  // R3
    logic [63:0] d; logic [31:0] r;
    mem_write(8'd5, 64'hA5A5_0F0F_1234_5678, 8'hFF);
    mem[5][67] = ~mem[5][67];
    mem_read(8'd5, d);
    check_eq("R3 data unchanged", 72'(d), 72'(64'hA5A5_0F0F_1234_5678));
    cfg_rd(2'd1, r);
    check_eq("R3 syndrome one-hot", 72'(r[15:8]), 72'(8'h08));
    cfg_wr(2'd1, 32'h3);
  endtask

  task automatic t_double();  // R4 R12
    logic [63:0] d; logic [31:0] r;
    mem_write(8'd20, 64'h0000_FFFF_0000_FFFF, 8'hFF);
    mem[20][1] = ~mem[20][1];
    mem[20][33] = ~mem[20][33];
    mem_read(8'd20, d);
    check_eq("R4 data uncorrected", 72'(d), 72'(64'h0000_FFFF_0000_FFFF ^ 64'h2_0000_0002));
    cfg_rd(2'd1, r);
    check_eq("R4 flags multi only", 72'(r[1:0]), 72'(2));
    @(negedge clk); @(negedge clk);
    check_eq("R12 multi not reported", 72'(sys_err), 72'(0));
    cfg_wr(2'd0, 32'h3A);
    @(negedge clk);
    check_eq("R12 multi reported", 72'(sys_err), 72'(1));
    cfg_wr(2'd0, 32'h1A);
    @(negedge clk);
    check_eq("R12 global gate", 72'(sys_err), 72'(0));
    cfg_wr(2'd1, 32'h3);
  endtask

  task automatic t_check_only();  // R5
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h01);
    mem_write(8'd6, 64'h1357_9BDF_2468_ACE0, 8'hFF);
    mem[6][40] = ~mem[6][40];
    mem_read(8'd6, d);
    check_eq("R5 data passed raw", 72'(d), 72'(64'h1357_9BDF_2468_ACE0 ^ (64'h1 << 40)));
    cfg_rd(2'd1, r); check_eq("R5 single flag", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h3);
  endtask

  task automatic t_off();  // R6
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h00);
    mem_write(8'd7, 64'hFFFF_0000_AAAA_5555, 8'hFF);
    check_eq("R6 check byte zero", 72'(mem[7][71:64]), 72'(0));
    mem[7][3] = ~mem[7][3];
    mem_read(8'd7, d);
    check_eq("R6 raw data", 72'(d), 72'(64'hFFFF_0000_AAAA_555D));
    cfg_rd(2'd1, r); check_eq("R6 no flags", 72'(r[1:0]), 72'(0));
  endtask

  task automatic t_diag();  // R7 R8 R10-style merge
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h06);
    mem_write(8'd8, 64'h1, 8'hFF);
    check_eq("R7 full write check zero", 72'(mem[8][71:64]), 72'(0));
    mem_read(8'd8, d);
    check_eq("R8 data not corrected", 72'(d), 72'(64'h1));
    cfg_rd(2'd1, r); check_eq("R8 error logged", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h3);
    mem_write(8'd9, 64'h0, 8'hFF);
    mem_read(8'd9, d);
    cfg_rd(2'd1, r); check_eq("R8 zero word clean", 72'(r[1:0]), 72'(0));
    mem_write(8'd8, 64'h0000_0000_0000_AB00, 8'h02);
    check_eq("R7 RMW word", mem[8], {8'h00, 64'h0000_0000_0000_AB01});
    cfg_wr(2'd1, 32'h3);
  endtask

  task automatic t_rmw_fix();  // R9
    logic [63:0] d; logic [31:0] r;
    cfg_wr(2'd0, 32'h02);
    mem_write(8'd10, 64'h0123_4567_89AB_CDEF, 8'hFF);
    mem[10][60] = ~mem[10][60];
    mem_write(8'd10, 64'h0000_0000_0000_005A, 8'h01);
    check_eq("R9 merged and repaired", 72'(mem[10][63:0]), 72'(64'h0123_4567_89AB_CD5A));
    cfg_rd(2'd1, r); check_eq("R9 read phase logged", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h3);
    mem_read(8'd10, d);
    check_eq("R9 readback", 72'(d), 72'(64'h0123_4567_89AB_CD5A));
    cfg_rd(2'd1, r); check_eq("R9 readback clean", 72'(r[1:0]), 72'(0));
  endtask

  task automatic t_rmw_multi();  // R10
    logic [63:0] d; logic [31:0] r;
    mem_write(8'd11, 64'hFEDC_BA98_7654_3210, 8'hFF);
    mem[11][2] = ~mem[11][2];
    mem[11][3] = ~mem[11][3];
    mem_write(8'd11, 64'hC300_0000_0000_0000, 8'h80);
    check_eq("R10 merge completed", 72'(mem[11][63:0]), 72'(64'hC3DC_BA98_7654_321C));
    cfg_rd(2'd1, r); check_eq("R10 multi flag", 72'(r[1:0]), 72'(2));
    cfg_wr(2'd1, 32'h3);
    mem_read(8'd11, d);
    check_eq("R10 readback", 72'(d), 72'(64'hC3DC_BA98_7654_321C));
  endtask

  task automatic t_sticky();  // R11
    logic [63:0] d; logic [31:0] r;
    mem_write(8'd12, 64'h5555_5555_5555_5555, 8'hFF);
    mem[12][9] = ~mem[12][9];
    mem_read(8'd12, d);
    mem_read(8'd10, d);
    cfg_rd(2'd1, r); check_eq("R11 flag survives clean read", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h0);
    cfg_rd(2'd1, r); check_eq("R11 writing 0 keeps flag", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h2);
    cfg_rd(2'd1, r); check_eq("R11 other bit keeps flag", 72'(r[1:0]), 72'(1));
    cfg_wr(2'd1, 32'h1);
    cfg_rd(2'd1, r); check_eq("R11 cleared by 1", 72'(r[1:0]), 72'(0));
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean_rw();
    t_single_fix();
    t_chk_bit();
    t_double();
    t_check_only();
    t_off();
    t_diag();
    t_rmw_fix();
    t_rmw_multi();
    t_sticky();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule